// File: doc/BRIEF.md
# Barrel Pipeline Hart Sequencer

This block is the issue controller for an interleaved pipeline that carries eight hardware threads (harts). Each hart has its own program counter and a small slot mode. In every clock cycle the block offers the fetch stage exactly one hart, visiting the harts in a fixed cyclic order. Neighbouring instructions in flight therefore always belong to different harts. As a result, the pipeline needs no operand forwarding, no stall detection and no dependency scheduling.

The pipeline reports back through two tagged channels. The first is a redirect carrying a resolved next-PC. It is applied before the hart's next turn comes round, so a taken branch costs no bubble and no predictor is needed. The second is a continue request for a long operation, such as a missed load or a divide. It marks the hart's next turn as a continuation of the instruction already in flight, at the same PC. The other harts keep their turns, and only the requesting hart waits. A per-hart enable turns a hart's turn into a bubble without disturbing the rotation.

Top module: `hart_sequencer`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, the offered hart is 0 and the continue flag is low. Every hart's first new-instruction slot after reset carries the RESET_VEC parameter as its PC.
- R2: The offered hart ID advances by one every cycle, wrapping from 7 back to 0. The order does not depend on enables, redirects or continue requests.
- R3: `fetch_valid` equals the enable bit of the offered hart. A slot whose hart is disabled leaves that hart's PC and mode unchanged.
- R4: After a valid new-instruction slot at PC p, the same hart's next valid slot offers p+4, unless a redirect or continue request intervenes.
- R5: A redirect tagged with hart h and target t, taken at any clock edge before h's next slot, makes that next slot offer PC t with `fetch_cont` low. The following slots continue from t with R4 stepping.
- R6: A continue request tagged with hart h, taken at any edge from h's own slot up to h's next slot, makes that next valid slot offer the PC of h's last issued instruction with `fetch_cont` high. Issuing the continuation clears the request, so holding for N rotations takes one request per rotation.
- R7: Redirect and continue requests change only the hart named by their 3-bit tag. Every other hart keeps its PC sequence and its mode.
- R8: When both requests name the same hart at the same edge, the redirect wins: the next slot offers the target with `fetch_cont` low. A redirect or continue request at the edge of the hart's own slot overrides the plain +4 advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hart_en | input | 8 | Per-hart enable; bit i gates hart i's slots |
| redir_valid | input | 1 | Redirect request present this cycle |
| redir_hart | input | 3 | Hart that the redirect applies to |
| redir_pc | input | 64 | Resolved next-PC for that hart |
| hold_valid | input | 1 | Continue request present this cycle |
| hold_hart | input | 3 | Hart whose next slot continues its current instruction |
| fetch_valid | output | 1 | This slot carries a real fetch (low means bubble) |
| fetch_hart | output | 3 | Hart owning this slot |
| fetch_pc | output | 64 | PC to fetch or continue for that hart |
| fetch_cont | output | 1 | High when the slot continues an in-flight instruction |

## Verification
The assertions take for granted that each feedback channel carries at most one tagged request per cycle. They also assume a continue request names a hart that has already issued the instruction to be continued, or else names a hart waiting for its first slot; the bound checker's PC expectation relies on this. The stimulus uses the single request port of each channel, so it cannot issue two requests on one channel in a cycle. Continue requests are timed to a hart's own slot or to the gap before its next one. Redirect and continue requests are placed both on the target hart's own slot edge and away from it, and together for the same hart.

// File: rtl/hseq_pkg.sv
package hseq_pkg;

    localparam int unsigned DEF_HARTS   = 8;
    localparam int unsigned DEF_PC_W    = 64;
    localparam int unsigned INSN_BYTES  = 4;

    // What a hart's next slot will offer
    typedef enum logic [1:0] {
        MODE_START = 2'd0,  // offer the stored PC as a fresh instruction
        MODE_SEQ   = 2'd1,  // offer stored PC + INSN_BYTES
        MODE_CONT  = 2'd2   // offer stored PC again as a continuation
    } slot_mode_e;

endpackage

// File: rtl/hseq_rotor.sv
module hseq_rotor #(
    parameter int unsigned NUM_HARTS = hseq_pkg::DEF_HARTS,
    localparam int unsigned HART_W   = $clog2(NUM_HARTS)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [HART_W-1:0] slot
);

    logic [HART_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (ptr_q == HART_W'(NUM_HARTS - 1)) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign slot = ptr_q;

endmodule

// File: rtl/hseq_hart_ctx.sv
module hseq_hart_ctx
    import hseq_pkg::*;
#(
    parameter int unsigned     PC_W      = DEF_PC_W,
    parameter logic [PC_W-1:0] RESET_VEC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue,      // this hart owns the current slot and is enabled
    input  logic            redir_hit,
    input  logic [PC_W-1:0] redir_pc,
    input  logic            hold_hit,
    output logic [PC_W-1:0] slot_pc,
    output slot_mode_e      slot_mode
);

    logic [PC_W-1:0] pc_q;
    slot_mode_e      mode_q;

    always_comb begin
        if (mode_q == MODE_SEQ) begin
            slot_pc = pc_q + PC_W'(INSN_BYTES);
        end else begin
            slot_pc = pc_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= RESET_VEC;
            mode_q <= MODE_START;
        end else if (redir_hit) begin
            pc_q   <= redir_pc;
            mode_q <= MODE_START;
        end else begin
            if (issue) begin
                pc_q <= slot_pc;
            end
            if (hold_hit) begin
                mode_q <= MODE_CONT;
            end else if (issue) begin
                mode_q <= MODE_SEQ;
            end
        end
    end

    assign slot_mode = mode_q;

endmodule

// File: rtl/hseq_issue_mux.sv
module hseq_issue_mux
    import hseq_pkg::*;
#(
    parameter int unsigned NUM_HARTS = DEF_HARTS,
    parameter int unsigned PC_W      = DEF_PC_W,
    localparam int unsigned HART_W   = $clog2(NUM_HARTS)
) (
    input  logic [HART_W-1:0]    slot,
    input  logic [NUM_HARTS-1:0] hart_en,
    input  logic [PC_W-1:0]      pcs   [NUM_HARTS],
    input  slot_mode_e           modes [NUM_HARTS],
    output logic                 fetch_valid,
    output logic [HART_W-1:0]    fetch_hart,
    output logic [PC_W-1:0]      fetch_pc,
    output logic                 fetch_cont
);

    always_comb begin
        fetch_hart  = slot;
        fetch_valid = hart_en[slot];
        fetch_pc    = pcs[slot];
        fetch_cont  = hart_en[slot] && (modes[slot] == MODE_CONT);
    end

endmodule

// File: rtl/hart_sequencer.sv
module hart_sequencer
    import hseq_pkg::*;
#(
    parameter int unsigned     NUM_HARTS = DEF_HARTS,
    parameter int unsigned     PC_W      = DEF_PC_W,
    parameter logic [PC_W-1:0] RESET_VEC = PC_W'(64'h0000_0000_8000_0000),
    localparam int unsigned    HART_W    = $clog2(NUM_HARTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_HARTS-1:0] hart_en,
    input  logic                 redir_valid,
    input  logic [HART_W-1:0]    redir_hart,
    input  logic [PC_W-1:0]      redir_pc,
    input  logic                 hold_valid,
    input  logic [HART_W-1:0]    hold_hart,
    output logic                 fetch_valid,
    output logic [HART_W-1:0]    fetch_hart,
    output logic [PC_W-1:0]      fetch_pc,
    output logic                 fetch_cont
);

    logic [HART_W-1:0] slot;
    logic [PC_W-1:0]   ctx_pc   [NUM_HARTS];
    slot_mode_e        ctx_mode [NUM_HARTS];

    hseq_rotor #(.NUM_HARTS(NUM_HARTS)) u_rotor (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    for (genvar i = 0; i < NUM_HARTS; i++) begin : g_hart
        logic issue_i, redir_i, hold_i;

        assign issue_i = (slot == HART_W'(i)) && hart_en[i];
        assign redir_i = redir_valid && (redir_hart == HART_W'(i));
        assign hold_i  = hold_valid  && (hold_hart  == HART_W'(i));

        hseq_hart_ctx #(.PC_W(PC_W), .RESET_VEC(RESET_VEC)) u_ctx (
            .clk       (clk),
            .rst       (rst),
            .issue     (issue_i),
            .redir_hit (redir_i),
            .redir_pc  (redir_pc),
            .hold_hit  (hold_i),
            .slot_pc   (ctx_pc[i]),
            .slot_mode (ctx_mode[i])
        );
    end

    hseq_issue_mux #(.NUM_HARTS(NUM_HARTS), .PC_W(PC_W)) u_mux (
        .slot        (slot),
        .hart_en     (hart_en),
        .pcs         (ctx_pc),
        .modes       (ctx_mode),
        .fetch_valid (fetch_valid),
        .fetch_hart  (fetch_hart),
        .fetch_pc    (fetch_pc),
        .fetch_cont  (fetch_cont)
    );

endmodule

// File: rtl/hseq_checker.sv
module hseq_checker #(
    parameter int unsigned     NUM_HARTS = 8,
    parameter int unsigned     PC_W      = 64,
    parameter logic [PC_W-1:0] RESET_VEC = '0,
    localparam int unsigned    HART_W    = $clog2(NUM_HARTS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_HARTS-1:0] hart_en,
    input logic                 redir_valid,
    input logic [HART_W-1:0]    redir_hart,
    input logic [PC_W-1:0]      redir_pc,
    input logic                 hold_valid,
    input logic [HART_W-1:0]    hold_hart,
    input logic                 fetch_valid,
    input logic [HART_W-1:0]    fetch_hart,
    input logic [PC_W-1:0]      fetch_pc,
    input logic                 fetch_cont
);

    // Per hart: last issued PC (or redirect / reset target) and whether the
    // next new slot should offer that value unchanged.
    logic [PC_W-1:0]      base_q  [NUM_HARTS];
    logic [NUM_HARTS-1:0] fresh_q;

    always_ff @(posedge clk) begin
        for (int h = 0; h < NUM_HARTS; h++) begin
            if (rst) begin
                base_q[h]  <= RESET_VEC;
                fresh_q[h] <= 1'b1;
            end else if (redir_valid && redir_hart == HART_W'(h)) begin
                base_q[h]  <= redir_pc;
                fresh_q[h] <= 1'b1;
            end else if (fetch_valid && fetch_hart == HART_W'(h)) begin
                base_q[h]  <= fetch_pc;
                fresh_q[h] <= 1'b0;
            end
        end
    end

    // R1: rotation restarts at hart 0 with no continuation
    a_r1_reset_slot: assert property (@(posedge clk)
        $fell(rst) |-> (fetch_hart == '0 && !fetch_cont));

    // R2: fixed cyclic order
    a_r2_rotation: assert property (@(posedge clk) disable iff (rst)
        !rst |=> fetch_hart == (($past(fetch_hart) == HART_W'(NUM_HARTS - 1))
                                ? '0 : $past(fetch_hart) + 1'b1));

    // R3: bubbles only for disabled harts
    a_r3_bubble: assert property (@(posedge clk) disable iff (rst)
        fetch_valid == hart_en[fetch_hart]);

    // R4: sequential step of one instruction
    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !fetch_cont && !fresh_q[fetch_hart])
        |-> fetch_pc == base_q[fetch_hart] + PC_W'(4));

    // R5: redirect / reset target offered unchanged at the next slot
    a_r5_target: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !fetch_cont && fresh_q[fetch_hart])
        |-> fetch_pc == base_q[fetch_hart]);

    // R6: continuation repeats the last issued PC
    a_r6_continue: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && fetch_cont) |-> fetch_pc == base_q[fetch_hart]);

endmodule

bind hart_sequencer hseq_checker #(
    .NUM_HARTS (NUM_HARTS),
    .PC_W      (PC_W),
    .RESET_VEC (RESET_VEC)
) u_hseq_chk (
    .clk         (clk),
    .rst         (rst),
    .hart_en     (hart_en),
    .redir_valid (redir_valid),
    .redir_hart  (redir_hart),
    .redir_pc    (redir_pc),
    .hold_valid  (hold_valid),
    .hold_hart   (hold_hart),
    .fetch_valid (fetch_valid),
    .fetch_hart  (fetch_hart),
    .fetch_pc    (fetch_pc),
    .fetch_cont  (fetch_cont)
);

// File: tb/hart_sequencer_test.sv
module hart_sequencer_test;

    localparam int          NH = 8;
    localparam logic [63:0] RV = 64'h0000_0000_8000_0000;

    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic [7:0]  en  = 8'hFF;
    logic [7:0]  nxt_en = 8'hFF;
    logic        rv_i = 1'b0;
    logic [2:0]  rh = '0;
    logic [63:0] rpc = '0;
    logic        hv = 1'b0;
    logic [2:0]  hh = '0;

    logic        f_valid;
    logic [2:0]  f_hart;
    logic [63:0] f_pc;
    logic        f_cont;

    hart_sequencer #(.NUM_HARTS(NH), .PC_W(64), .RESET_VEC(RV)) uut (
        .clk(clk), .rst(rst), .hart_en(en),
        .redir_valid(rv_i), .redir_hart(rh), .redir_pc(rpc),
        .hold_valid(hv), .hold_hart(hh),
        .fetch_valid(f_valid), .fetch_hart(f_hart),
        .fetch_pc(f_pc), .fetch_cont(f_cont)
    );

    typedef struct packed {
        logic [2:0]  hart;
        logic        valid;
        logic [63:0] pc;
        logic        cont;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];
    int    vectors = 0;
    int    errors  = 0;
    string cur_req = "R1";

    // Reference state built from the requirements
    logic [63:0] m_pc   [NH];
    int          m_mode [NH];   // 0 fresh, 1 step, 2 continue
    int          m_ptr;

    task automatic model_reset();
        for (int i = 0; i < NH; i++) begin
            m_pc[i]   = RV;
            m_mode[i] = 0;
        end
        m_ptr = 0;
    endtask

    // Driver: one cycle of stimulus, pushes what the slot must show
    task automatic cycle(input logic do_r, input int r_h, input logic [63:0] r_t,
                         input logic do_h, input int h_h);
        exp_t e;
        @(negedge clk);
        rst  = 1'b0;
        en   = nxt_en;
        rv_i = do_r; rh = r_h[2:0]; rpc = r_t;
        hv   = do_h; hh = h_h[2:0];
        e.hart  = m_ptr[2:0];
        e.valid = en[m_ptr];
        e.pc    = (m_mode[m_ptr] == 1) ? m_pc[m_ptr] + 64'd4 : m_pc[m_ptr];
        e.cont  = en[m_ptr] && (m_mode[m_ptr] == 2);
        exp_q.push_back(e);
        req_q.push_back(cur_req);
        if (e.valid) begin
            m_pc[m_ptr]   = e.pc;
            m_mode[m_ptr] = 1;
        end
        if (do_h) m_mode[h_h] = 2;
        if (do_r) begin
            m_pc[r_h]   = r_t;
            m_mode[r_h] = 0;
        end
        m_ptr = (m_ptr + 1) % NH;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cycle(1'b0, 0, 64'd0, 1'b0, 0);
    endtask

    task automatic to_slot(input int h);
        while (m_ptr != h) cycle(1'b0, 0, 64'd0, 1'b0, 0);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected slot per cycle and compares
    always @(negedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t  e;
            string r;
            logic  bad;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            vectors++;
            bad = (f_hart !== e.hart) || (f_valid !== e.valid) || (f_cont !== e.cont)
                  || (e.valid && (f_pc !== e.pc));
            if (bad) begin
                errors++;
                $display("FAIL %s slot: actual hart=%0d v=%b pc=%h c=%b expected hart=%0d v=%b pc=%h c=%b",
                         r, f_hart, f_valid, f_pc, f_cont, e.hart, e.valid, e.pc, e.cont);
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state seen at the ports
        chk("R1", "hart", {61'd0, f_hart}, 64'd0);
        chk("R1", "pc",   f_pc, RV);
        chk("R1", "cont", {63'd0, f_cont}, 64'd0);

        cur_req = "R1"; idle(8);           // first rotation offers RESET_VEC
        cur_req = "R2"; idle(16);          // strict rotation
        cur_req = "R4"; idle(16);          // +4 stepping

        // R3: disable harts 2 and 5, then restore
        cur_req = "R3"; nxt_en = 8'b1101_1011; idle(16);
        nxt_en = 8'hFF; idle(8);

        // R5: redirect hart 3 between its slots
        cur_req = "R5"; to_slot(4);
        cycle(1'b1, 3, 64'h0000_0000_0001_0000, 1'b0, 0);
        idle(16);

        // R8: redirect on the hart's own slot edge beats the +4 step
        cur_req = "R8"; to_slot(3);
        cycle(1'b1, 3, 64'h0000_0000_0002_0000, 1'b0, 0);
        idle(8);

        // R6: hold hart 6 for three rotations, request on its own slot
        cur_req = "R6";
        for (int n = 0; n < 3; n++) begin
            to_slot(6);
            cycle(1'b0, 0, 64'd0, 1'b1, 6);
        end
        idle(16);
        // R6: request placed between slots
        to_slot(0); cycle(1'b0, 0, 64'd0, 1'b1, 4); idle(16);

        // R7: tagged requests touch only their own hart
        cur_req = "R7"; to_slot(0);
        cycle(1'b1, 1, 64'h0000_0000_0000_3000, 1'b1, 5);
        idle(16);

        // R8: both requests for one hart at one edge, redirect wins
        cur_req = "R8"; to_slot(5);
        cycle(1'b1, 2, 64'h0000_0000_0000_4000, 1'b1, 2);
        idle(16);

        // R1: reset mid-run returns every hart to RESET_VEC
        @(negedge clk);
        rst = 1'b1; rv_i = 1'b0; hv = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        #1;
        chk("R1", "hart after reset", {61'd0, f_hart}, 64'd0);
        chk("R1", "pc after reset",   f_pc, RV);
        cur_req = "R1"; idle(16);

        @(negedge clk);
        @(negedge clk);
        #2;
        finish_run();
    end

endmodule